// File: doc/BRIEF.md
# Block-Burst Bus Arbiter for Eight DMA Channels

This block decides which of eight DMA channels owns the shared bus. Each channel raises a request line when it has a block to move. The arbiter answers with a one-hot grant. The granted channel keeps the bus for its whole block burst. When the channel pulses a block-done strobe, the arbiter takes a new decision at that clock edge, so the grant moves in the following cycle.

A global enable input gates every new grant. A policy input selects how the winner is chosen. With fixed priority, the lowest-numbered requesting channel wins. With round robin, the search starts at the channel after the one that last finished a block, and wraps around. The enable and policy inputs are sampled only when a decision is taken. Changing either of them during a burst therefore never disturbs the burst in progress.

Top module: `dma_bus_arbiter`

## Requirements
- R1: After reset, no grant is asserted. The round-robin search starting point is channel 0, so the first round-robin winner is the lowest-numbered requester.
- R2: While no grant is held and `arb_enable` is 0, no grant is issued, whatever the requests are.
- R3: `bus_grant` never has more than one bit set.
- R4: With `arb_policy` = 0 (fixed priority), a decision grants the lowest-numbered requesting channel. Channel 0 has the highest priority and channel 7 the lowest.
- R5: With `arb_policy` = 1 (round robin), a decision grants the first requesting channel found by searching upward and wrapping. The search starts one channel past the last channel that finished a block.
- R6: While a grant is held and `blk_done` is 0, the grant stays unchanged, whatever the requests, enable or policy are.
- R7: When a grant is held and `blk_done` is 1 at a clock edge, the grant in the next cycle goes to the new winner. It is cleared if there is no request or if enable is 0.
- R8: A change of `arb_policy` during a burst has no effect until the next decision. At that decision, the new policy value is used.
- R9: Clearing `arb_enable` during a burst does not end the burst. After its `blk_done`, no new grant is issued while enable stays 0.
- R10: A `blk_done` pulse while no grant is held has no effect. It neither issues a grant by itself nor moves the round-robin starting point.
- R11: While no grant is held, `arb_enable` is 1 and at least one request is set, a grant to a requesting channel appears one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arb_enable | input | 1 | Global enable for new grants |
| arb_policy | input | 1 | 0 = fixed priority, 1 = round robin |
| ch_req | input | 8 | Per-channel bus request |
| blk_done | input | 1 | Strobe from the granted channel: its block burst ends this cycle |
| bus_grant | output | 8 | One-hot grant, all zero when the bus is free |

## Verification
The end of a burst can fall in the same cycle as a change of the global inputs. These are the cases where the design is most likely to go wrong. The bench raises `blk_done` in the same cycle that `arb_enable` falls. It also raises `blk_done` in the same cycle that `arb_policy` flips, with several channels requesting. In each case it expects the decision to follow the values present at that edge: an empty grant in the first case, and the winner under the new policy in the second. It also checks that the round-robin search starts from the channel that has just finished, not from the one that finished before it.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef enum logic {
    POL_FIXED = 1'b0,
    POL_RR    = 1'b1
  } arb_pol_e;

endpackage

// File: rtl/arb_fixed_pick.sv
// Lowest-index-wins selector built as a ripple of "already taken" flags.
module arb_fixed_pick #(
  parameter int N_CH = 8
) (
  input  logic [N_CH-1:0] req,
  output logic [N_CH-1:0] gnt
);

  logic [N_CH:0] taken;

  assign taken[0] = 1'b0;

  for (genvar i = 0; i < N_CH; i++) begin : g_chain
    assign gnt[i]       = req[i] & ~taken[i];
    assign taken[i + 1] = taken[i] | req[i];
  end

endmodule

// File: rtl/arb_rr_pick.sv
// Rotating selector: the search begins at start_idx and wraps.
module arb_rr_pick #(
  parameter int N_CH = 8,
  localparam int IW  = $clog2(N_CH)
) (
  input  logic [N_CH-1:0] req,
  input  logic [IW-1:0]   start_idx,
  output logic [N_CH-1:0] gnt
);

  function automatic logic [N_CH-1:0] rot_down(input logic [N_CH-1:0] v,
                                               input logic [IW-1:0] s);
    logic [2*N_CH-1:0] dbl;
    dbl = {v, v} >> s;
    return dbl[N_CH-1:0];
  endfunction

  function automatic logic [N_CH-1:0] rot_up(input logic [N_CH-1:0] v,
                                             input logic [IW-1:0] s);
    logic [2*N_CH-1:0] dbl;
    dbl = {v, v} << s;
    return dbl[2*N_CH-1:N_CH];
  endfunction

  logic [N_CH-1:0] req_rot, gnt_rot;

  assign req_rot = rot_down(req, start_idx);

  arb_fixed_pick #(.N_CH(N_CH)) u_first (
    .req (req_rot),
    .gnt (gnt_rot)
  );

  assign gnt = rot_up(gnt_rot, start_idx);

endmodule

// File: rtl/arb_last_ptr.sv
// Remembers which channel finished a block most recently.
module arb_last_ptr #(
  parameter int N_CH = 8,
  localparam int IW  = $clog2(N_CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] grant,
  input  logic            finish,
  output logic [IW-1:0]   cur_idx,
  output logic [IW-1:0]   last_idx
);

  function automatic logic [IW-1:0] oh_to_idx(input logic [N_CH-1:0] oh);
    logic [IW-1:0] idx;
    idx = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (oh[i]) idx = idx | IW'(i);
    end
    return idx;
  endfunction

  assign cur_idx = oh_to_idx(grant);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_idx <= IW'(N_CH - 1);
    end else if (finish) begin
      last_idx <= cur_idx;
    end
  end

endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
  import dma_arb_pkg::*;
#(
  parameter int N_CH = 8,
  localparam int IW  = $clog2(N_CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arb_enable,
  input  logic            arb_policy,
  input  logic [N_CH-1:0] ch_req,
  input  logic            blk_done,
  output logic [N_CH-1:0] bus_grant
);

  function automatic logic [IW-1:0] next_idx(input logic [IW-1:0] i);
    return (i == IW'(N_CH - 1)) ? '0 : i + 1'b1;
  endfunction

  // Named internal events, visible to the bound checker.
  logic            busy;
  logic            any_req;
  logic            burst_end;
  logic            arb_decide;
  logic [IW-1:0]   cur_idx;
  logic [IW-1:0]   last_idx;
  logic [IW-1:0]   base_idx;
  logic [IW-1:0]   rr_start;
  logic [N_CH-1:0] fix_gnt;
  logic [N_CH-1:0] rr_gnt;
  logic [N_CH-1:0] win_gnt;
  logic [N_CH-1:0] grant_q;
  arb_pol_e        pol;

  assign pol        = arb_pol_e'(arb_policy);
  assign busy       = |grant_q;
  assign any_req    = |ch_req;
  assign burst_end  = busy & blk_done;
  assign arb_decide = (burst_end | ~busy) & arb_enable & any_req;

  // The channel that finishes now counts as the last one for this decision.
  assign base_idx = burst_end ? cur_idx : last_idx;
  assign rr_start = next_idx(base_idx);

  arb_fixed_pick #(.N_CH(N_CH)) u_fixed (
    .req (ch_req),
    .gnt (fix_gnt)
  );

  arb_rr_pick #(.N_CH(N_CH)) u_rr (
    .req       (ch_req),
    .start_idx (rr_start),
    .gnt       (rr_gnt)
  );

  assign win_gnt = (pol == POL_RR) ? rr_gnt : fix_gnt;

  arb_last_ptr #(.N_CH(N_CH)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .grant    (grant_q),
    .finish   (burst_end),
    .cur_idx  (cur_idx),
    .last_idx (last_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
    end else if (arb_decide) begin
      grant_q <= win_gnt;
    end else if (burst_end) begin
      grant_q <= '0;
    end
  end

  assign bus_grant = grant_q;

endmodule

// File: rtl/dma_bus_arbiter_chk.sv
module dma_bus_arbiter_chk #(
  parameter int N_CH = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            arb_enable,
  input logic            arb_policy,
  input logic [N_CH-1:0] ch_req,
  input logic            blk_done,
  input logic [N_CH-1:0] bus_grant,
  input logic            arb_decide
);

  assert_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_grant));

  assert_hold_burst_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_grant != '0 && !blk_done) |=> (bus_grant == $past(bus_grant)));

  assert_idle_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_grant == '0 && !arb_enable) |=> (bus_grant == '0));

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_grant != '0 && blk_done && ch_req == '0) |=> (bus_grant == '0));

  assert_enable_off_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_grant != '0 && blk_done && !arb_enable) |=> (bus_grant == '0));

  assert_idle_grant_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_grant == '0 && arb_enable && ch_req != '0)
      |=> ((bus_grant & $past(ch_req)) != '0));

  assert_fixed_lowest_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_decide && !arb_policy)
      |=> (bus_grant == ($past(ch_req) & (~$past(ch_req) + 1'b1))));

  assert_decide_serves_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
    arb_decide |=> ((bus_grant & $past(ch_req)) != '0));

endmodule

bind dma_bus_arbiter dma_bus_arbiter_chk #(.N_CH(N_CH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .arb_enable (arb_enable),
  .arb_policy (arb_policy),
  .ch_req     (ch_req),
  .blk_done   (blk_done),
  .bus_grant  (bus_grant),
  .arb_decide (arb_decide)
);

// File: tb/dma_bus_arbiter_tb.sv
`timescale 1ns/1ps
module dma_bus_arbiter_tb;

  localparam int N = 8;

  typedef struct {
    logic [N-1:0] exp;
    string        tag;
  } item_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         arb_enable = 1'b0;
  logic         arb_policy = 1'b0;
  logic [N-1:0] ch_req = '0;
  logic         blk_done = 1'b0;
  logic [N-1:0] bus_grant;

  int errors = 0;
  int checks = 0;
  bit reported = 0;
  item_t sb[$];

  // Reference state: granted channel (-1 = none) and last finisher.
  int m_gnt = -1;
  int m_last = N - 1;

  always #10 clk = ~clk;

  dma_bus_arbiter u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .arb_enable (arb_enable),
    .arb_policy (arb_policy),
    .ch_req     (ch_req),
    .blk_done   (blk_done),
    .bus_grant  (bus_grant)
  );

  function automatic logic [N-1:0] as_vec(input int idx);
    return (idx < 0) ? '0 : (N'(1) << idx);
  endfunction

  function automatic int ref_pick(input logic [N-1:0] r, input bit rr, input int last);
    if (!rr) begin
      for (int i = 0; i < N; i++) if (r[i]) return i;
    end else begin
      for (int k = 1; k <= N; k++) if (r[(last + k) % N]) return (last + k) % N;
    end
    return -1;
  endfunction

  task automatic report(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: bus_grant=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: apply one cycle of stimulus and queue the grant expected after the edge.
  task automatic step(input bit en, input bit pol, input logic [N-1:0] r,
                      input bit done, input string tag);
    item_t it;
    bit fin;
    @(negedge clk);
    arb_enable = en;
    arb_policy = pol;
    ch_req     = r;
    blk_done   = done;
    fin = (m_gnt >= 0) && done;
    if (fin) m_last = m_gnt;
    if (m_gnt >= 0 && !done) begin
      // burst continues
    end else if (en && r != '0) begin
      m_gnt = ref_pick(r, pol, m_last);
    end else begin
      m_gnt = -1;
    end
    it.exp = as_vec(m_gnt);
    it.tag = tag;
    sb.push_back(it);
  endtask

  // Monitor: compare one queued expectation per clock, away from the edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        report(bus_grant, it.exp, it.tag);
      end
    end
  end

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    if (!reported) begin
      reported = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    report(bus_grant, '0, "R1 reset");
    rst_n = 1'b1;

    // R2: disabled while idle
    step(0, 0, 8'hFF, 0, "R2");
    step(0, 1, 8'h81, 1, "R2");
    step(0, 0, 8'h10, 0, "R2");

    // R1: first round-robin winner is the lowest requester
    step(1, 1, 8'h24, 0, "R1 R11");
    step(1, 1, 8'h24, 0, "R6");
    step(1, 1, 8'h00, 1, "R7");

    // R4 and R11: fixed priority from idle
    step(1, 0, 8'h28, 0, "R4 R11");
    // R6: hold while requests change
    step(1, 0, 8'h01, 0, "R6");
    step(0, 1, 8'hFF, 0, "R6");
    // R7: done moves grant to the fixed winner
    step(1, 0, 8'h81, 1, "R7 R4");
    step(1, 0, 8'h81, 0, "R6");
    step(1, 0, 8'h00, 1, "R7");
    step(1, 0, 8'h00, 0, "R7");

    // R5: round robin rotation with all requesting
    step(1, 1, 8'hFF, 0, "R5");
    for (int k = 0; k < 10; k++) step(1, 1, 8'hFF, 1, "R5");
    step(1, 1, 8'h00, 1, "R5");
    // R5: wrap with sparse requests
    step(1, 1, 8'h82, 0, "R5");
    step(1, 1, 8'h82, 1, "R5");
    step(1, 1, 8'h82, 1, "R5");
    step(1, 1, 8'h00, 1, "R5");

    // R10: done while idle leaves pointer alone
    step(0, 1, 8'h00, 1, "R10");
    step(0, 1, 8'h00, 1, "R10");
    step(1, 1, 8'hFF, 0, "R10");
    step(1, 1, 8'h00, 1, "R10");

    // R8: policy flip mid burst, used at next decision
    step(1, 0, 8'h30, 0, "R8");
    step(1, 1, 8'h30, 0, "R8");
    step(1, 1, 8'h31, 1, "R8");
    step(1, 0, 8'h31, 1, "R8");
    step(1, 0, 8'h00, 1, "R8");

    // R9: enable dropped mid burst
    step(1, 0, 8'h04, 0, "R9");
    step(0, 0, 8'h04, 0, "R9");
    step(0, 0, 8'h04, 0, "R9");
    step(0, 0, 8'h04, 1, "R9");
    step(0, 0, 8'hFF, 0, "R9");
    step(1, 0, 8'h40, 0, "R9");
    // coincident done with enable fall
    step(1, 0, 8'hFF, 0, "R9");
    step(0, 0, 8'hFF, 1, "R9");
    step(0, 0, 8'hFF, 0, "R9");
    // coincident done with policy flip
    step(1, 0, 8'h11, 0, "R8");
    step(1, 1, 8'h11, 1, "R8");
    step(1, 0, 8'h00, 1, "R8");

    // Mixed traffic, checked against the reference model (R3 by equality)
    lfsr = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[9:0] != 10'd0, lfsr[11], lfsr[7:0] & {lfsr[15:12], lfsr[3:0]},
           lfsr[14] | lfsr[2], "R3 mix");
    end

    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
    if (!reported) begin
      reported = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
    $finish;
  end

endmodule